// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This block performs 32x32-bit multiplies and folds the 64-bit product into an accumulator made of two 32-bit halves, HI and LO. An operation is launched with a start strobe, together with two operands, a two-bit opcode, a signedness flag and a result-half select. The opcode chooses one of four operations. A plain multiply replaces the accumulator with the product. A negated multiply replaces it with zero minus the product. Multiply-add adds the product to the accumulator, and multiply-subtract takes the product away from it. All arithmetic wraps modulo 2^64. When the operation completes, the unit returns one 32-bit word as the instruction result. The half select picks whether that word is the new HI or the new LO.

The operands are extended and multiplied in a first registered stage. The accumulate step and the HI/LO update happen in a second stage. A completion pulse marks the cycle in which the new HI/LO and the result word are visible. A separate write port loads HI and LO directly. That port is used to preset or restore the accumulator, and it yields to an operation that is completing in the same cycle.

Top module: `mac_hilo`

## Requirements
- R1: While reset is high and after it is released, HI, LO and the result word read zero and the done pulse is low.
- R2: With unsigned flag = 0, both operands are sign-extended to 64 bits before the multiply, and plain multiply (opcode 2'b00) writes the 64-bit product with its upper 32 bits to HI and its lower 32 bits to LO.
- R3: With unsigned flag = 1, both operands are zero-extended to 64 bits before the multiply.
- R4: Negated multiply (opcode 2'b01) writes zero minus the product into {HI,LO}. The previous accumulator contents have no effect on the result.
- R5: Multiply-add (opcode 2'b10) writes {HI,LO} + product modulo 2^64.
- R6: Multiply-subtract (opcode 2'b11) writes {HI,LO} - product modulo 2^64.
- R7: With half select = 1, the result word equals the new HI. With half select = 0, it equals the new LO.
- R8: A start accepted in cycle N produces a done pulse of exactly one cycle in cycle N+2. The new HI, LO and result word are visible in that same cycle.
- R9: A start that arrives in the cycle after an accepted start (operation in flight) is ignored. It produces no done pulse and does not change HI or LO.
- R10: When no operation is completing, a write-enable pulse loads HI and LO from the write port, visible in the next cycle.
- R11: A write-enable in the cycle in which an operation completes its accumulate step is dropped, and the operation's result is kept.
- R12: With no operation completing and no write, HI and LO hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch an operation |
| op_i | input | 2 | 00 multiply, 01 negated multiply, 10 multiply-add, 11 multiply-subtract |
| uns_i | input | 1 | 1 = unsigned operands, 0 = signed |
| sel_hi_i | input | 1 | 1 = result is new HI, 0 = new LO |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| wr_en_i | input | 1 | Direct load of HI and LO |
| wr_hi_i | input | 32 | Value for HI on a direct load |
| wr_lo_i | input | 32 | Value for LO on a direct load |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Selected half of the updated accumulator |
| hi_o | output | 32 | Current HI |
| lo_o | output | 32 | Current LO |

## Verification
The assertions watch the timing skeleton on every cycle. They check that an accepted start always reaches the done pulse one cycle after the in-flight cycle, that done never lasts two cycles, that no second launch happens while busy, that an uncontested write lands, that HI/LO hold when idle, and that the result word matches one of the two halves. The arithmetic can only be shown by the bench's scenarios, which compare every completion against an independent 64-bit model. These cover sign versus zero extension at the extreme operands, wrap-around of add and subtract, the accumulator being ignored by negated multiply, a dropped start during flight, and a write that collides with a completing operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        MAC_OP_MUL  = 2'b00,
        MAC_OP_NEG  = 2'b01,
        MAC_OP_ADD  = 2'b10,
        MAC_OP_SUB  = 2'b11
    } mac_op_e;

    typedef struct packed {
        mac_op_e op;
        logic    uns;
        logic    sel_hi;
    } mac_cmd_t;

    function automatic logic needs_acc(input mac_op_e op);
        return (op == MAC_OP_ADD) || (op == MAC_OP_SUB);
    endfunction

endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  mac_cmd_t          cmd_i,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              valid_o,
    output mac_cmd_t          cmd_o,
    output logic [ACC_W-1:0]  prod_o
);

    logic signed [DATA_W:0]    a_ext;
    logic signed [DATA_W:0]    b_ext;
    logic signed [ACC_W+1:0]   full;

    always_comb begin
        a_ext = {(~cmd_i.uns) & a[DATA_W-1], a};
        b_ext = {(~cmd_i.uns) & b[DATA_W-1], b};
        full  = a_ext * b_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            cmd_o   <= '0;
            prod_o  <= '0;
        end else begin
            valid_o <= accept;
            if (accept) begin
                cmd_o  <= cmd_i;
                prod_o <= full[ACC_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mac_combine.sv
module mac_combine
    import mac_pkg::*;
#(
    parameter int ACC_W = 64
) (
    input  mac_op_e          op,
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] next
);

    logic [ACC_W-1:0] base;
    logic             subtract;

    always_comb begin
        base     = needs_acc(op) ? acc : '0;
        subtract = (op == MAC_OP_NEG) || (op == MAC_OP_SUB);
        next     = subtract ? (base - prod) : (base + prod);
    end

endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
    parameter int DATA_W = 32,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_done,
    input  logic [ACC_W-1:0]  op_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_hi,
    input  logic [DATA_W-1:0] wr_lo,
    output logic [DATA_W-1:0] hi,
    output logic [DATA_W-1:0] lo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= '0;
            lo <= '0;
        end else if (op_done) begin
            hi <= op_val[ACC_W-1:DATA_W];
            lo <= op_val[DATA_W-1:0];
        end else if (wr_en) begin
            hi <= wr_hi;
            lo <= wr_lo;
        end
    end

endmodule

// File: rtl/mac_hilo.sv
module mac_hilo
    import mac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              uns_i,
    input  logic              sel_hi_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_hi_i,
    input  logic [DATA_W-1:0] wr_lo_i,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic [DATA_W-1:0] hi_o,
    output logic [DATA_W-1:0] lo_o
);

    localparam int ACC_W = 2 * DATA_W;

    mac_cmd_t         cmd_in;
    mac_cmd_t         s1_cmd;
    logic             s1_valid;
    logic             accept;
    logic [ACC_W-1:0] s1_prod;
    logic [ACC_W-1:0] acc_next;
    logic [DATA_W-1:0] half_sel;

    assign cmd_in = '{op: mac_op_e'(op_i), uns: uns_i, sel_hi: sel_hi_i};
    assign accept = start_i & ~s1_valid;

    mac_mul_stage #(.DATA_W(DATA_W)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .cmd_i   (cmd_in),
        .a       (a_i),
        .b       (b_i),
        .valid_o (s1_valid),
        .cmd_o   (s1_cmd),
        .prod_o  (s1_prod)
    );

    mac_combine #(.ACC_W(ACC_W)) u_comb (
        .op   (s1_cmd.op),
        .acc  ({hi_o, lo_o}),
        .prod (s1_prod),
        .next (acc_next)
    );

    mac_acc_reg #(.DATA_W(DATA_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .op_done (s1_valid),
        .op_val  (acc_next),
        .wr_en   (wr_en_i),
        .wr_hi   (wr_hi_i),
        .wr_lo   (wr_lo_i),
        .hi      (hi_o),
        .lo      (lo_o)
    );

    assign half_sel = s1_cmd.sel_hi ? acc_next[ACC_W-1:DATA_W] : acc_next[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o   <= 1'b0;
            result_o <= '0;
        end else begin
            done_o <= s1_valid;
            if (s1_valid) begin
                result_o <= half_sel;
            end
        end
    end

endmodule

// File: rtl/mac_hilo_checker.sv
module mac_hilo_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_hi_i,
    input logic [DATA_W-1:0] wr_lo_i,
    input logic              inflight,
    input logic              done_o,
    input logic [DATA_W-1:0] result_o,
    input logic [DATA_W-1:0] hi_o,
    input logic [DATA_W-1:0] lo_o
);

    AST_ACCEPT_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (start_i && !inflight) |=> inflight); // R8

    AST_FLIGHT_DONE: assert property (@(posedge clk) disable iff (rst)
        inflight |=> done_o); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
        inflight |=> !inflight); // R9

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !inflight) |=> (hi_o == $past(wr_hi_i) && lo_o == $past(wr_lo_i))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inflight && !wr_en_i) |=> ($stable(hi_o) && $stable(lo_o))); // R12

    AST_RESULT_HALF: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o == hi_o || result_o == lo_o)); // R7

endmodule

bind mac_hilo mac_hilo_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .wr_en_i  (wr_en_i),
    .wr_hi_i  (wr_hi_i),
    .wr_lo_i  (wr_lo_i),
    .inflight (s1_valid),
    .done_o   (done_o),
    .result_o (result_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
);

// File: tb/mac_hilo_bench.sv
`timescale 1ns/1ps
module mac_hilo_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        uns_i = 1'b0;
    logic        sel_hi_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_hi_i = '0;
    logic [31:0] wr_lo_i = '0;
    logic        done_o;
    logic [31:0] result_o;
    logic [31:0] hi_o;
    logic [31:0] lo_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [63:0] model_acc = '0;

    typedef struct packed {
        logic [31:0] res;
        logic [63:0] acc;
        int          due;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mac_hilo u_mac_hilo (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .uns_i(uns_i),
        .sel_hi_i(sel_hi_i), .a_i(a_i), .b_i(b_i), .wr_en_i(wr_en_i),
        .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .done_o(done_o),
        .result_o(result_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ext(input logic [31:0] v, input bit u);
        return u ? {32'h0, v} : {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] model(input logic [1:0] op, input bit u,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc);
        logic [63:0] p;
        p = ext(a, u) * ext(b, u);
        case (op)
            2'b00:   return p;
            2'b01:   return 64'd0 - p;
            2'b10:   return acc + p;
            default: return acc - p;
        endcase
    endfunction

    // Monitor: pops expected completions as done pulses appear.
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (exp_q.size() == 0) begin
                check("R9 stray done", 64'(done_o), 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " R8 latency"}, 64'(cyc), 64'(e.due));
                check({t, " R7 result"}, 64'(result_o), 64'(e.res));
                check({t, " hilo"}, {hi_o, lo_o}, e.acc);
            end
        end
    end

    task automatic issue(input logic [1:0] op, input bit u, input bit sel,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_t e;
        model_acc = model(op, u, a, b, model_acc);
        e.acc = model_acc;
        e.res = sel ? model_acc[63:32] : model_acc[31:0];
        @(negedge clk);
        e.due = cyc + 2;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        start_i = 1'b1; op_i = op; uns_i = u; sel_hi_i = sel; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_hl(input logic [31:0] h, input logic [31:0] l);
        @(negedge clk);
        wr_en_i = 1'b1; wr_hi_i = h; wr_lo_i = l;
        @(negedge clk);
        wr_en_i = 1'b0;
        model_acc = {h, l};
        check("R10 write load", {hi_o, lo_o}, {h, l});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset hilo", {hi_o, lo_o}, 64'd0);
        check("R1 reset done/result", {31'd0, done_o, result_o}, 64'd0);

        issue(2'b00, 1'b0, 1'b0, 32'hFFFF_FFFD, 32'd5, "R2 signed mul");
        issue(2'b00, 1'b1, 1'b1, 32'hFFFF_FFFD, 32'd5, "R3 unsigned mul sel hi");
        issue(2'b00, 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
        issue(2'b00, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 max*max");

        write_hl(32'h1234_5678, 32'h9ABC_DEF0);
        issue(2'b01, 1'b0, 1'b0, 32'd7, 32'd3, "R4 neg signed");
        issue(2'b01, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd2, "R4 neg unsigned");

        issue(2'b10, 1'b0, 1'b0, 32'hFFFF_FFFE, 32'd3, "R5 madd signed");
        issue(2'b10, 1'b1, 1'b1, 32'hFFFF_FFFE, 32'd3, "R5 madd unsigned");
        write_hl(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        issue(2'b10, 1'b1, 1'b1, 32'd1, 32'd1, "R5 madd wrap");

        issue(2'b11, 1'b0, 1'b0, 32'd1, 32'd1, "R6 msub wrap below zero");
        issue(2'b11, 1'b1, 1'b1, 32'h0001_0000, 32'h0001_0000, "R6 msub unsigned");
        issue(2'b11, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd4, "R6 msub signed neg product R7");

        // R12: idle cycles leave HI/LO unchanged
        repeat (5) @(negedge clk);
        check("R12 hold", {hi_o, lo_o}, model_acc);

        // R9: start raised again in the in-flight cycle is ignored
        begin
            exp_t e;
            model_acc = model(2'b00, 1'b1, 32'd6, 32'd7, model_acc);
            e.acc = model_acc;
            e.res = model_acc[31:0];
            @(negedge clk);
            e.due = cyc + 2;
            exp_q.push_back(e);
            tag_q.push_back("R9 first op");
            start_i = 1'b1; op_i = 2'b00; uns_i = 1'b1; sel_hi_i = 1'b0;
            a_i = 32'd6; b_i = 32'd7;
            @(negedge clk);
            op_i = 2'b10; a_i = 32'd1000; b_i = 32'd1000;
            @(negedge clk);
            start_i = 1'b0;
            repeat (3) @(negedge clk);
            check("R9 ignored start hilo", {hi_o, lo_o}, model_acc);
        end

        // R11: write colliding with a completing operation is dropped
        begin
            exp_t e;
            model_acc = model(2'b00, 1'b0, 32'd9, 32'hFFFF_FFFF, model_acc);
            e.acc = model_acc;
            e.res = model_acc[63:32];
            @(negedge clk);
            e.due = cyc + 2;
            exp_q.push_back(e);
            tag_q.push_back("R11 op vs write");
            start_i = 1'b1; op_i = 2'b00; uns_i = 1'b0; sel_hi_i = 1'b1;
            a_i = 32'd9; b_i = 32'hFFFF_FFFF;
            @(negedge clk);
            start_i = 1'b0;
            wr_en_i = 1'b1; wr_hi_i = 32'hDEAD_BEEF; wr_lo_i = 32'hCAFE_F00D;
            @(negedge clk);
            wr_en_i = 1'b0;
            @(negedge clk);
            check("R11 write dropped", {hi_o, lo_o}, model_acc);
        end

        repeat (4) @(negedge clk);
        check("R8 all completions seen", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule